// File: doc/BRIEF.md
# Dual-Mode Burst Address Sequencer

This block produces the word address for every beat of a four-beat burst into a synchronous memory. A burst begins when either of two independent start strobes is high at a rising clock edge: one strobe is for the processor side and one is for the memory controller side. At that edge the block captures the whole external address, and that captured address is the first beat. Each later edge with the step input high, and with neither strobe high, moves the two low address bits one position through the burst order. The upper bits stay fixed until the next strobe.

The burst order is chosen at run time by an order-select input, which is sampled when the burst starts. In interleaved order, beat k uses the starting low bits XOR k. In linear order, beat k uses the starting low bits plus k, modulo 4. The two-bit beat counter wraps, so a burst never leaves its aligned four-word block, and stepping past the fourth beat returns to the first. A small state machine tracks the beat. Its states are IDLE (no burst since reset), BEAT0, BEAT1, BEAT2 and BEAT3. Its transitions are: LOAD, from any state to BEAT0 when a strobe is seen; STEP, from BEATn to BEATn+1 when the step input is high; WRAP, from BEAT3 to BEAT0 when the step input is high; HOLD, which keeps the state when nothing is asserted; and RESET, from any state to IDLE.

Top module: `burst_addr_seq`

## Requirements
- R1: While the synchronous reset is high, and after it until the first strobe, addr_out is zero. A step input given before any burst has started has no effect.
- R2: When start_cpu or start_ctl is high at a rising edge, addr_out equals the addr_in value sampled at that edge immediately after that edge.
- R3: Bits addr_out[ADDR_W-1:2] keep the value captured at the last strobe until the next strobe or reset.
- R4: With order_sel = 1 (interleaved) captured at the strobe, addr_out[1:0] on beat k equals the starting low bits XOR k.
- R5: With order_sel = 0 (linear) captured at the strobe, addr_out[1:0] on beat k equals (starting low bits + k) mod 4.
- R6: During a burst, the beat index advances by exactly one on an edge where step is high and both strobes are low. With step low and both strobes low, addr_out holds its value.
- R7: When a strobe and step are high at the same edge, the strobe wins: the new address is loaded and the beat index restarts at 0.
- R8: A step after the fourth beat wraps back to beat 0 of the same four-word block, and the wrapping continues on later steps.
- R9: Changing order_sel in the middle of a burst has no effect until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_cpu | input | 1 | Processor-side burst start strobe |
| start_ctl | input | 1 | Controller-side burst start strobe |
| step | input | 1 | Advance to the next beat |
| order_sel | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| addr_in | input | ADDR_W | External address captured at a strobe |
| addr_out | output | ADDR_W | Address of the current beat |

## Verification
Every state register drives addr_out directly through a small amount of combinational logic. Because of this, a wrong beat index, a wrong captured order bit or a wrong captured start address appears on addr_out in the same cycle that follows the faulty edge. The bench compares addr_out one time step after every rising edge. Any error in the beat index, the wrap or the strobe priority is therefore reported at the first beat where it occurs. A mode bit that is latched wrongly only shows up on beats 1 to 3, because beat 0 looks the same in both orders. For that reason the bench runs full bursts in both orders and with every possible starting offset.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BEAT0 = 3'd1,
        ST_BEAT1 = 3'd2,
        ST_BEAT2 = 3'd3,
        ST_BEAT3 = 3'd4
    } beat_state_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_t;

endpackage

// File: rtl/burst_ctrl_fsm.sv
module burst_ctrl_fsm
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    output logic [BEAT_W-1:0] beat_idx,
    output logic              active
);

    beat_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = ST_BEAT0;
        end else if (step) begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BEAT0: state_d = ST_BEAT1;
                ST_BEAT1: state_d = ST_BEAT2;
                ST_BEAT2: state_d = ST_BEAT3;
                ST_BEAT3: state_d = ST_BEAT0;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        active   = 1'b1;
        beat_idx = '0;
        unique case (state_q)
            ST_IDLE:  active   = 1'b0;
            ST_BEAT0: beat_idx = 2'd0;
            ST_BEAT1: beat_idx = 2'd1;
            ST_BEAT2: beat_idx = 2'd2;
            ST_BEAT3: beat_idx = 2'd3;
            default:  active   = 1'b0;
        endcase
    end

    // R6 R8
    step_advances_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && active) |=> (beat_idx == $past(beat_idx) + 2'd1));

    // R7
    load_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (active && beat_idx == 2'd0));

    // R1
    idle_step_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !load) |=> !active);

endmodule

// File: rtl/burst_addr_capture.sv
module burst_addr_capture #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              order_in,
    output logic [ADDR_W-3:0] upper_q,
    output logic [1:0]        start_lo_q,
    output logic              order_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q    <= '0;
            start_lo_q <= '0;
            order_q    <= 1'b0;
        end else if (load) begin
            upper_q    <= addr_in[ADDR_W-1:2];
            start_lo_q <= addr_in[1:0];
            order_q    <= order_in;
        end
    end

    // R3
    upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(upper_q));

    // R9
    order_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(order_q));

endmodule

// File: rtl/burst_low_gen.sv
module burst_low_gen
    import burst_seq_pkg::*;
(
    input  logic [1:0]        start_lo,
    input  logic [BEAT_W-1:0] beat_idx,
    input  logic              order,
    output logic [1:0]        low_out
);

    burst_order_t ord;
    assign ord = burst_order_t'(order);

    always_comb begin
        unique case (ord)
            ORD_INTERLEAVE: low_out = start_lo ^ beat_idx;
            ORD_LINEAR:     low_out = start_lo + beat_idx;
            default:        low_out = start_lo;
        endcase
    end

    // R4 R5
    always_comb begin
        if (beat_idx == 2'd0) begin
            beat0_is_start_chk: assert (low_out == start_lo);
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_cpu,
    input  logic              start_ctl,
    input  logic              step,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    logic              load;
    logic              step_only;
    logic [BEAT_W-1:0] beat_idx;
    logic              active;
    logic [ADDR_W-3:0] upper_q;
    logic [1:0]        start_lo_q;
    logic              order_q;
    logic [1:0]        low_bits;

    assign load      = start_cpu | start_ctl;
    assign step_only = step & ~load;

    burst_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .step     (step_only),
        .beat_idx (beat_idx),
        .active   (active)
    );

    burst_addr_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .addr_in    (addr_in),
        .order_in   (order_sel),
        .upper_q    (upper_q),
        .start_lo_q (start_lo_q),
        .order_q    (order_q)
    );

    burst_low_gen u_low (
        .start_lo (start_lo_q),
        .beat_idx (beat_idx),
        .order    (order_q),
        .low_out  (low_bits)
    );

    assign addr_out = {upper_q, low_bits};

    // R2
    strobe_loads_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (addr_out == $past(addr_in)));

    // R6
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(addr_out));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        rst |=> (addr_out == '0));

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_cpu = 1'b0;
    logic          start_ctl = 1'b0;
    logic          step = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [AW-3:0] m_upper = '0;
    logic [1:0]    m_start = '0;
    logic          m_ord = 1'b0;
    logic [1:0]    m_k = '0;
    bit            m_active = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .start_cpu(start_cpu), .start_ctl(start_ctl),
        .step(step), .order_sel(order_sel), .addr_in(addr_in), .addr_out(addr_out)
    );

    function automatic logic [1:0] beat_low(logic [1:0] s, logic [1:0] k, logic ord);
        return ord ? (s ^ k) : 2'(s + k);
    endfunction

    function automatic logic [AW-1:0] model_addr();
        return {m_upper, beat_low(m_start, m_k, m_ord)};
    endfunction

    task automatic cycle(input bit r, input bit sc, input bit sk, input bit st,
                         input bit ord, input logic [AW-1:0] a, input string tag);
        logic [AW-1:0] exp;
        @(negedge clk);
        rst = r; start_cpu = sc; start_ctl = sk; step = st; order_sel = ord; addr_in = a;
        @(posedge clk);
        if (r) begin
            m_active = 0; m_upper = '0; m_start = '0; m_ord = 0; m_k = '0;
        end else if (sc || sk) begin
            m_active = 1; m_upper = a[AW-1:2]; m_start = a[1:0]; m_ord = ord; m_k = '0;
        end else if (st && m_active) begin
            m_k = m_k + 2'd1;
        end
        #1;
        exp = model_addr();
        checks++;
        if (addr_out !== exp) begin
            errors++;
            $display("FAIL %s: addr_out=%h expected=%h", tag, addr_out, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        cycle(1, 1, 0, 1, 1, 18'h3FFFF, "R1 reset");
        cycle(1, 0, 0, 0, 0, '0, "R1 reset");
        cycle(0, 0, 0, 1, 1, '0, "R1 idle step");
        cycle(0, 0, 0, 1, 0, '0, "R1 idle step");
        // R4 interleaved from offset 2: 2,3,0,1 then wrap
        cycle(0, 1, 0, 0, 1, 18'h1234A, "R2 cpu strobe");
        cycle(0, 0, 0, 1, 1, '0, "R4 beat1");
        cycle(0, 0, 0, 1, 0, '0, "R9 order change");
        cycle(0, 0, 0, 1, 0, '0, "R4 beat3");
        cycle(0, 0, 0, 1, 1, '0, "R8 wrap");
        cycle(0, 0, 0, 1, 1, '0, "R8 wrap again");
        cycle(0, 0, 0, 0, 1, 18'h3FFFF, "R3 upper hold");
        // R5 linear from offset 3: 3,0,1,2 then wrap
        cycle(0, 0, 1, 0, 0, 18'h2AB37, "R2 ctl strobe");
        cycle(0, 0, 0, 1, 0, '0, "R5 beat1");
        cycle(0, 0, 0, 1, 1, '0, "R5 beat2");
        cycle(0, 0, 0, 1, 0, '0, "R5 beat3");
        cycle(0, 0, 0, 1, 0, '0, "R8 linear wrap");
        cycle(0, 0, 0, 0, 0, '0, "R6 hold");
        // R7 strobe and step together
        cycle(0, 0, 0, 1, 1, '0, "R6 step");
        cycle(0, 1, 1, 1, 1, 18'h00F01, "R7 strobe wins");
        cycle(0, 0, 0, 1, 1, '0, "R7 restart beat1");
        cycle(1, 0, 0, 1, 0, '0, "R1 reset mid-burst");
        cycle(0, 0, 0, 1, 0, '0, "R1 step after reset");
        // every offset in both orders, full bursts
        for (int o = 0; o < 2; o++) begin
            for (int s = 0; s < 4; s++) begin
                cycle(0, 1, 0, 0, o[0], {16'hA5C3, 2'(s)}, "R2 offset sweep");
                for (int b = 0; b < 4; b++)
                    cycle(0, 0, 0, 1, ~o[0], '0, o[0] ? "R4 sweep" : "R5 sweep");
            end
        end
        for (int i = 0; i < 3000; i++) begin
            bit sc, sk, st, ord;
            logic [AW-1:0] a;
            string tag;
            sc  = ($urandom % 8) == 0;
            sk  = ($urandom % 8) == 0;
            st  = ($urandom % 2) == 0;
            ord = $urandom % 2;
            a   = AW'($urandom);
            if (sc && sk && st) tag = "R7 random";
            else if (sc || sk)  tag = "R2 random";
            else if (st)        tag = m_ord ? "R4 random" : "R5 random";
            else                tag = "R6 random";
            cycle(0, sc, sk, st, ord, a, tag);
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule